// File: doc/BRIEF.md
# Subarray-Aware Bank Command Scheduler

This block sits in a memory controller and drives the command stream of a single DRAM bank whose subarrays can each hold a row open at the same time. Requests arrive with a subarray index, a row and a column. Each subarray keeps its own local row buffer, but only one of them at a time is connected to the bank's shared data lines. The scheduler turns each request into the commands needed to serve it: open a row, connect a subarray, read or write, or close a row.

A status table holds one entry for each subarray. Each entry records whether the subarray is open, which row it holds, and whether it is the connected one. When a request targets a subarray that already holds the right row but is not connected, the cost is a single select command. No other subarray is closed. Only a subarray that holds a different row is precharged. Two programmable counts set the idle time between a select and the following read or write. Two parameters set the idle time after a precharge and after an activate.

With the defaults (8 subarrays, 9-bit rows), the table is 88 bits.

Top module: `subarray_sched`

## Requirements
- R1: After reset, `cmd_valid` is low, `req_ready` is high and every subarray counts as closed, so the first request to any subarray starts with an activate. Command codes on `cmd_op` are: 0 none, 1 activate, 2 select, 3 read, 4 write, 5 precharge.
- R2: A request to a closed subarray is served by an activate carrying its row, then a select of that subarray, then its column command.
- R3: A request to a subarray that is open on the requested row but not connected is served by a select followed by its column command, with no activate and no precharge.
- R4: A request to the connected subarray on its open row is served by the column command alone.
- R5: A request to a subarray open on another row issues a precharge to that subarray only, then activate, select and column. Other subarrays keep their rows open throughout.
- R6: After a select exactly one subarray is connected, and it is the selected one. Read and write commands only go to the connected subarray, on its open row.
- R7: Between a select and the following read there are at least `cfg_sel_rd` idle cycles, and before a write at least `cfg_sel_wr` idle cycles. When nothing else is waiting, the count is exact.
- R8: At least T_RP idle cycles follow a precharge and at least T_RCD idle cycles follow an activate before the next command. A column command needs no idle cycle after it.
- R9: At most one command is issued per cycle. A queued request that hits the connected subarray's open row is served before any other; otherwise the oldest request is served.
- R10: `req_ready` is low while QDEPTH requests are queued. Every accepted request receives exactly one read or write command carrying its subarray, row, column and direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Queue can take a request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_sa | input | $clog2(NSA) | Target subarray |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| cfg_sel_rd | input | TW | Idle cycles from select to read |
| cfg_sel_wr | input | TW | Idle cycles from select to write |
| cmd_valid | output | 1 | A command is issued this cycle |
| cmd_op | output | 3 | Command code (see R1) |
| cmd_sa | output | $clog2(NSA) | Subarray the command targets |
| cmd_row | output | ROW_W | Row for activate and column commands |
| cmd_col | output | COL_W | Column for read and write |

## Verification
The bench targets the following corner cases:
- Returning to a subarray that was left open behind another one. A design that closes rows too eagerly emits a precharge and an activate there instead of a lone select.
- A row conflict inside the connected subarray. Precharging the wrong subarray, or keeping it marked connected, sends a column command to a closed row.
- A connected-row hit queued behind an older request. A purely age-ordered design serves them in the wrong order.
- Separate read and write select gaps. A design that swaps them issues the column command too early for one direction.
- A full queue. An off-by-one in the ready logic either drops a request or stalls it.

A random phase checks every command against a shadow table built from the command port.

// File: rtl/sasched_pkg.sv
package sasched_pkg;
  typedef enum logic [2:0] {
    OP_NOP = 3'd0,
    OP_ACT = 3'd1,
    OP_SEL = 3'd2,
    OP_RD  = 3'd3,
    OP_WR  = 3'd4,
    OP_PRE = 3'd5
  } cmd_op_e;
endpackage

// File: rtl/req_queue.sv
module req_queue #(
  parameter int DEPTH = 4,
  parameter int W     = 8,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [W-1:0]     push_data,
  input  logic             pop,
  input  logic [IW-1:0]    pop_idx,
  output logic [W-1:0]     ent_o [DEPTH],
  output logic [DEPTH-1:0] vld_o,
  output logic             ready_o
);
  logic [W-1:0]     ent_q [DEPTH];
  logic [DEPTH-1:0] vld_q;
  logic [W-1:0]     sh_e  [DEPTH];
  logic [DEPTH-1:0] sh_v;
  logic [W-1:0]     nx_e  [DEPTH];
  logic [DEPTH-1:0] nx_v;
  logic [IW-1:0]    slot;

  // remove the popped entry and close the hole, keeping age order by index
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      if (pop && i >= int'(pop_idx)) begin
        if (i < DEPTH-1) begin
          sh_e[i] = ent_q[i+1];
          sh_v[i] = vld_q[i+1];
        end else begin
          sh_e[i] = ent_q[i];
          sh_v[i] = 1'b0;
        end
      end else begin
        sh_e[i] = ent_q[i];
        sh_v[i] = vld_q[i];
      end
    end
    slot = '0;
    for (int i = DEPTH-1; i >= 0; i--)
      if (!sh_v[i]) slot = IW'(i);
    nx_e = sh_e;
    nx_v = sh_v;
    if (push) begin
      nx_e[slot] = push_data;
      nx_v[slot] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) vld_q <= '0;
    else     vld_q <= nx_v;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) ent_q[i] <= nx_e[i];
  end

  assign ent_o   = ent_q;
  assign vld_o   = vld_q;
  assign ready_o = !vld_q[DEPTH-1];

  // R10
  pop_valid_chk: assert property (@(posedge clk) disable iff (rst)
    pop |-> vld_q[pop_idx]);
  // R10
  push_room_chk: assert property (@(posedge clk) disable iff (rst)
    push |-> !vld_q[DEPTH-1]);
endmodule

// File: rtl/sa_table.sv
module sa_table import sasched_pkg::*; #(
  parameter int NSA   = 8,
  parameter int ROW_W = 9,
  parameter int SA_W  = $clog2(NSA)
) (
  input  logic             clk,
  input  logic             rst,
  input  cmd_op_e          upd_op,
  input  logic [SA_W-1:0]  upd_sa,
  input  logic [ROW_W-1:0] upd_row,
  output logic [NSA-1:0]   open_o,
  output logic [NSA-1:0]   link_o,
  output logic [ROW_W-1:0] rows_o [NSA]
);
  logic [NSA-1:0]   open_q;
  logic [NSA-1:0]   link_q;
  logic [ROW_W-1:0] row_mem [NSA];

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= '0;
      link_q <= '0;
    end else begin
      case (upd_op)
        OP_ACT: open_q[upd_sa] <= 1'b1;
        OP_PRE: begin
          open_q[upd_sa] <= 1'b0;
          link_q[upd_sa] <= 1'b0;
        end
        OP_SEL: begin
          link_q         <= '0;
          link_q[upd_sa] <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (upd_op == OP_ACT) row_mem[upd_sa] <= upd_row;
  end

  assign open_o = open_q;
  assign link_o = link_q;
  assign rows_o = row_mem;

  // R6
  one_link_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(link_q));
  // R6
  sel_link_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_op == OP_SEL) |=> ($countones(link_q) == 1 && link_q[$past(upd_sa)]));
  // R5
  link_open_chk: assert property (@(posedge clk) disable iff (rst)
    (link_q & ~open_q) == '0);
  // R5
  pre_close_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_op == OP_PRE) |=> !open_q[$past(upd_sa)]);
endmodule

// File: rtl/subarray_sched.sv
module subarray_sched import sasched_pkg::*; #(
  parameter int NSA    = 8,
  parameter int ROW_W  = 9,
  parameter int COL_W  = 7,
  parameter int QDEPTH = 4,
  parameter int TW     = 4,
  parameter int T_RP   = 2,
  parameter int T_RCD  = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [$clog2(NSA)-1:0]  req_sa,
  input  logic [ROW_W-1:0]        req_row,
  input  logic [COL_W-1:0]        req_col,
  input  logic [TW-1:0]           cfg_sel_rd,
  input  logic [TW-1:0]           cfg_sel_wr,
  output logic                    cmd_valid,
  output logic [2:0]              cmd_op,
  output logic [$clog2(NSA)-1:0]  cmd_sa,
  output logic [ROW_W-1:0]        cmd_row,
  output logic [COL_W-1:0]        cmd_col
);
  localparam int SA_W = $clog2(NSA);
  localparam int E_W  = 1 + SA_W + ROW_W + COL_W;
  localparam int QI_W = $clog2(QDEPTH);
  localparam int IDW  = TW + 2;

  logic [E_W-1:0]    ent [QDEPTH];
  logic [QDEPTH-1:0] vld;
  logic [NSA-1:0]    open_v, link_v;
  logic [ROW_W-1:0]  rows [NSA];

  logic              e_wr  [QDEPTH];
  logic [SA_W-1:0]   e_sa  [QDEPTH];
  logic [ROW_W-1:0]  e_row [QDEPTH];
  logic [COL_W-1:0]  e_col [QDEPTH];
  logic [QDEPTH-1:0] link_hit;

  logic [QI_W-1:0]   pidx;
  cmd_op_e           nxt_op;
  logic [TW-1:0]     gap_q;
  logic              pop;

  req_queue #(.DEPTH(QDEPTH), .W(E_W)) u_queue (
    .clk(clk), .rst(rst),
    .push(req_valid && req_ready),
    .push_data({req_write, req_sa, req_row, req_col}),
    .pop(pop), .pop_idx(pidx),
    .ent_o(ent), .vld_o(vld), .ready_o(req_ready)
  );

  sa_table #(.NSA(NSA), .ROW_W(ROW_W)) u_table (
    .clk(clk), .rst(rst),
    .upd_op(nxt_op), .upd_sa(e_sa[pidx]), .upd_row(e_row[pidx]),
    .open_o(open_v), .link_o(link_v), .rows_o(rows)
  );

  for (genvar i = 0; i < QDEPTH; i++) begin : g_unpack
    assign e_wr[i]  = ent[i][E_W-1];
    assign e_sa[i]  = ent[i][E_W-2 -: SA_W];
    assign e_row[i] = ent[i][ROW_W+COL_W-1 -: ROW_W];
    assign e_col[i] = ent[i][COL_W-1:0];
    assign link_hit[i] = vld[i] && open_v[e_sa[i]] && link_v[e_sa[i]]
                         && (rows[e_sa[i]] == e_row[i]);
  end

  // oldest connected-row hit wins; otherwise the head of the queue
  always_comb begin
    pidx = '0;
    for (int i = QDEPTH-1; i >= 0; i--)
      if (link_hit[i]) pidx = QI_W'(i);
  end

  always_comb begin
    nxt_op = OP_NOP;
    if (vld[0] && gap_q == '0) begin
      if (!open_v[e_sa[pidx]])                   nxt_op = OP_ACT;
      else if (rows[e_sa[pidx]] != e_row[pidx])  nxt_op = OP_PRE;
      else if (!link_v[e_sa[pidx]])              nxt_op = OP_SEL;
      else                                       nxt_op = e_wr[pidx] ? OP_WR : OP_RD;
    end
  end

  assign pop = (nxt_op == OP_RD) || (nxt_op == OP_WR);

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q <= '0;
    end else begin
      case (nxt_op)
        OP_PRE:  gap_q <= TW'(T_RP);
        OP_ACT:  gap_q <= TW'(T_RCD);
        OP_SEL:  gap_q <= e_wr[pidx] ? cfg_sel_wr : cfg_sel_rd;
        OP_RD, OP_WR: gap_q <= '0;
        default: if (gap_q != '0) gap_q <= gap_q - 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_valid <= 1'b0;
      cmd_op    <= OP_NOP;
      cmd_sa    <= '0;
      cmd_row   <= '0;
      cmd_col   <= '0;
    end else begin
      cmd_valid <= (nxt_op != OP_NOP);
      cmd_op    <= nxt_op;
      cmd_sa    <= e_sa[pidx];
      cmd_row   <= e_row[pidx];
      cmd_col   <= e_col[pidx];
    end
  end

  // spacing checker built from the command port
  logic [IDW-1:0] chk_idle;
  logic [2:0]     chk_last;
  always_ff @(posedge clk) begin
    if (rst) begin
      chk_idle <= '0;
      chk_last <= OP_NOP;
    end else if (cmd_valid) begin
      chk_idle <= '0;
      chk_last <= cmd_op;
    end else if (chk_idle != '1) begin
      chk_idle <= chk_idle + 1'b1;
    end
  end

  // R7
  sel_rd_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && chk_last == OP_SEL && cmd_op == OP_RD) |-> chk_idle >= IDW'(cfg_sel_rd));
  // R7
  sel_wr_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && chk_last == OP_SEL && cmd_op == OP_WR) |-> chk_idle >= IDW'(cfg_sel_wr));
  // R8
  pre_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && chk_last == OP_PRE) |-> chk_idle >= IDW'(T_RP));
  // R8
  act_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && chk_last == OP_ACT) |-> chk_idle >= IDW'(T_RCD));
  // R6
  col_target_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && (cmd_op == OP_RD || cmd_op == OP_WR)) |->
      (open_v[cmd_sa] && link_v[cmd_sa] && rows[cmd_sa] == cmd_row));
  // R2
  act_open_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_ACT) |-> (open_v[cmd_sa] && rows[cmd_sa] == cmd_row));
endmodule

// File: tb/sim_subarray_sched.sv
module sim_subarray_sched;
  localparam int NSA = 8, ROW_W = 9, COL_W = 7, QDEPTH = 4, TW = 4;
  localparam int T_RP = 2, T_RCD = 3, SA_W = 3;

  logic clk, rst, req_valid, req_ready, req_write, cmd_valid;
  logic [SA_W-1:0]  req_sa, cmd_sa;
  logic [ROW_W-1:0] req_row, cmd_row;
  logic [COL_W-1:0] req_col, cmd_col;
  logic [TW-1:0]    cfg_sel_rd, cfg_sel_wr;
  logic [2:0]       cmd_op;

  subarray_sched #(.NSA(NSA), .ROW_W(ROW_W), .COL_W(COL_W), .QDEPTH(QDEPTH),
                   .TW(TW), .T_RP(T_RP), .T_RCD(T_RCD)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_sa(req_sa), .req_row(req_row), .req_col(req_col),
    .cfg_sel_rd(cfg_sel_rd), .cfg_sel_wr(cfg_sel_wr), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_sa(cmd_sa), .cmd_row(cmd_row), .cmd_col(cmd_col));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int nchk = 0, nfail = 0, cyc = 0;
  int log_op [4096], log_sa [4096], log_row [4096], log_col [4096], log_cyc [4096];
  int nlog = 0;
  bit sh_open [NSA];
  int sh_row [NSA];
  int sh_link = -1, last_op = 0, last_cyc = -100;
  int p_w [1024], p_sa [1024], p_row [1024], p_col [1024];
  bit p_live [1024];
  int np = 0, npend = 0;
  int m_op, m_sa, m_row, m_col, m_need, m_idle, m_j;
  bit m_found;

  task automatic chk(bit ok, string rq, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  // monitor: log every command and check it against a shadow table
  always @(negedge clk) begin
    cyc++;
    if (!rst && cmd_valid) begin
      m_op = int'(cmd_op); m_sa = int'(cmd_sa); m_row = int'(cmd_row); m_col = int'(cmd_col);
      log_op[nlog] = m_op; log_sa[nlog] = m_sa; log_row[nlog] = m_row;
      log_col[nlog] = m_col; log_cyc[nlog] = cyc; nlog++;
      m_idle = cyc - last_cyc - 1;
      case (last_op)
        5: m_need = T_RP;
        1: m_need = T_RCD;
        2: m_need = (m_op == 4) ? int'(cfg_sel_wr) : int'(cfg_sel_rd);
        default: m_need = 0;
      endcase
      if (last_op == 2) chk(m_idle >= m_need, "R7 select spacing", m_idle, m_need);
      else              chk(m_idle >= m_need, "R8 spacing", m_idle, m_need);
      case (m_op)
        1: begin
          chk(!sh_open[m_sa], "R2 activate to closed subarray", int'(sh_open[m_sa]), 0);
          sh_open[m_sa] = 1'b1; sh_row[m_sa] = m_row;
        end
        5: begin
          chk(sh_open[m_sa], "R5 precharge to open subarray", int'(sh_open[m_sa]), 1);
          sh_open[m_sa] = 1'b0;
          if (sh_link == m_sa) sh_link = -1;
        end
        2: begin
          chk(sh_open[m_sa] && sh_link != m_sa, "R3 select to open unconnected", sh_link, m_sa);
          sh_link = m_sa;
        end
        3, 4: begin
          chk(sh_open[m_sa] && sh_link == m_sa && sh_row[m_sa] == m_row,
              "R6 column to connected open row", sh_link, m_sa);
          m_found = 1'b0;
          for (int j = 0; j < np; j++) begin
            if (!m_found && p_live[j] && p_sa[j] == m_sa && p_row[j] == m_row &&
                p_col[j] == m_col && p_w[j] == ((m_op == 4) ? 1 : 0)) begin
              m_found = 1'b1; m_j = j;
            end
          end
          if (m_found) begin p_live[m_j] = 1'b0; npend--; end
          chk(m_found, "R10 column matches an accepted request", m_col, -1);
        end
        default: chk(1'b0, "R1 command code", m_op, 0);
      endcase
      last_op = m_op; last_cyc = cyc;
    end
  end

  task automatic push(int w, int sa, int row, int col);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'(w); req_sa = SA_W'(sa);
    req_row = ROW_W'(row); req_col = COL_W'(col);
    while (!req_ready) @(negedge clk);
    p_w[np] = w; p_sa[np] = sa; p_row[np] = row; p_col[np] = col;
    p_live[np] = 1'b1; np++; npend++;
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic drain();
    int k = 0;
    while (npend != 0 && k < 4000) begin @(negedge clk); k++; end
    repeat (4) @(negedge clk);
    chk(npend == 0, "R10 every request served", npend, 0);
  endtask

  task automatic exp_cmd(int i, int op, int sa, int row, int col, string rq);
    chk(i < nlog && log_op[i] == op && log_sa[i] == sa &&
        (row < 0 || log_row[i] == row) && (col < 0 || log_col[i] == col),
        rq, (i < nlog) ? log_op[i] : -1, op);
  endtask

  task automatic exp_gap(int i, int g, string rq);
    chk(log_cyc[i] - log_cyc[i-1] - 1 == g, rq, log_cyc[i] - log_cyc[i-1] - 1, g);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog R10 actual=%0d expected=0", npend);
    summary();
  end

  initial begin
    int b;
    rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_sa = '0; req_row = '0; req_col = '0;
    cfg_sel_rd = 4'd2; cfg_sel_wr = 4'd5;
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(cmd_valid == 1'b0, "R1 no command after reset", int'(cmd_valid), 0);
    chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);

    // R2: closed subarray
    b = nlog; push(0, 3, 5, 11); drain();
    chk(nlog - b == 3, "R2 command count", nlog - b, 3);
    exp_cmd(b, 1, 3, 5, -1, "R2 activate");
    exp_cmd(b+1, 2, 3, -1, -1, "R2 select");
    exp_cmd(b+2, 3, 3, 5, 11, "R2 read");
    exp_gap(b+1, T_RCD, "R8 activate gap");
    exp_gap(b+2, 2, "R7 read select gap");

    // R4: connected hit
    b = nlog; push(0, 3, 5, 12); drain();
    chk(nlog - b == 1, "R4 command count", nlog - b, 1);
    exp_cmd(b, 3, 3, 5, 12, "R4 direct read");

    // R5: another subarray opens while sa3 stays open
    b = nlog; push(0, 1, 7, 1); drain();
    chk(nlog - b == 3, "R5 no precharge for other subarray", nlog - b, 3);
    exp_cmd(b, 1, 1, 7, -1, "R5 activate sa1");

    // R3: back to open sa3 with select only
    b = nlog; push(0, 3, 5, 2); drain();
    chk(nlog - b == 2, "R3 command count", nlog - b, 2);
    exp_cmd(b, 2, 3, -1, -1, "R3 select");
    exp_cmd(b+1, 3, 3, 5, 2, "R3 read");

    // R5: row conflict in connected subarray
    b = nlog; push(1, 3, 9, 4); drain();
    chk(nlog - b == 4, "R5 command count", nlog - b, 4);
    exp_cmd(b, 5, 3, -1, -1, "R5 precharge sa3");
    exp_cmd(b+1, 1, 3, 9, -1, "R5 activate new row");
    exp_cmd(b+2, 2, 3, -1, -1, "R5 select");
    exp_cmd(b+3, 4, 3, 9, 4, "R5 write");
    exp_gap(b+1, T_RP, "R8 precharge gap");
    exp_gap(b+3, 5, "R7 write select gap");

    // R9: connected hit overtakes older request
    b = nlog; push(1, 1, 7, 5); push(0, 3, 9, 6); push(0, 1, 7, 7); drain();
    chk(nlog - b == 5, "R9 command count", nlog - b, 5);
    exp_cmd(b, 2, 1, -1, -1, "R9 select sa1");
    exp_cmd(b+1, 4, 1, 7, 5, "R9 write sa1");
    exp_cmd(b+2, 3, 1, 7, 7, "R9 younger hit first");
    exp_cmd(b+3, 2, 3, -1, -1, "R9 then select sa3");
    exp_cmd(b+4, 3, 3, 9, 6, "R9 older read last");
    exp_gap(b+2, 0, "R8 back-to-back column");

    // R10: full queue
    @(negedge clk); cfg_sel_wr = 4'd15;
    b = nlog;
    push(1, 5, 2, 0); push(0, 5, 2, 1); push(0, 5, 2, 2); push(0, 5, 2, 3);
    @(negedge clk);
    chk(req_ready == 1'b0, "R10 ready low when full", int'(req_ready), 0);
    push(0, 5, 2, 4); drain();
    chk(nlog - b == 7, "R10 command count", nlog - b, 7);
    exp_cmd(b+2, 4, 5, 2, 0, "R10 write first");
    exp_gap(b+2, 15, "R7 long write gap");
    for (int i = 1; i <= 4; i++) begin
      exp_cmd(b+2+i, 3, 5, 2, i, "R9 reads in age order");
      exp_gap(b+2+i, 0, "R9 one column per cycle");
    end

    // random phase
    @(negedge clk); cfg_sel_rd = 4'd3; cfg_sel_wr = 4'd1;
    void'($urandom(32'd4242));
    for (int n = 0; n < 300; n++) begin
      push(int'($urandom % 2), int'($urandom % 4), int'($urandom % 3), int'($urandom % 128));
      if ($urandom % 4 == 0) repeat (int'($urandom % 6)) @(negedge clk);
    end
    drain();
    summary();
  end
endmodule